// File: doc/BRIEF.md
# Retention Latch Sensor Conditioner

This block cleans up the signal from a single retention-latch sensor on a hot-plug slot. The sensor pin is active-low and reads high while the latch is open. The pin is first resynchronized into the block clock domain. A new level is then accepted only after it has held continuously for a programmable number of millisecond ticks, ten by default. The accepted level is published as a stable latch state.

Each accepted transition, in either direction, sets a sticky change flag that software clears by a write-one strobe. When the change flag is set and both the per-source change enable and the global hot-plug interrupt enable are on, the block raises a level interrupt request. That request goes to exactly one of two delivery outputs, picked by a mode input: message-signalled, or legacy wire-emulated.

Right after reset there is no valid history to debounce against. Once the synchronizer holds real data, the first sample is therefore loaded straight into the stable state, and that load does not count as a change.

Top module: `latch_sensor_evt`

## Requirements
- R1: `latch_open` is 1 when the debounced sensor pin is high (latch open) and 0 when it is low (latch closed).
- R2: A new pin level is accepted only on the STABLE_MS-th (default 10th) `ms_tick` during which it has differed continuously from `latch_open`. With fewer ticks, `latch_open` is unchanged.
- R3: If the pin returns to the current stable level before acceptance, the tick count restarts from zero.
- R4: Every accepted transition, open-to-closed or closed-to-open, sets `chg_sts` one clock after `latch_open` changes, and `chg_sts` stays set.
- R5: After reset is released, the pin level is loaded into `latch_open` within SYNC_STAGES+1 clocks, with no tick needed.
- R6: The load right after reset does not set `chg_sts`.
- R7: A cycle with `clr_w1c` = 1 clears `chg_sts` when no change is accepted in that cycle.
- R8: If a change is accepted in the same cycle as `clr_w1c`, `chg_sts` stays 1.
- R9: An interrupt request is active exactly while `chg_sts`, `chg_en` and `hp_irq_en` are all 1, and it stays active for as long as all three remain 1.
- R10: `msg_sel` = 1 routes the request to `irq_msi`, and `msg_sel` = 0 routes it to `irq_intx`. The two outputs are never both 1.
- R11: During reset, `latch_open` = 1, `chg_sts` = 0, and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_n | input | 1 | Raw latch sensor pin, high = open |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| chg_en | input | 1 | Change interrupt enable |
| hp_irq_en | input | 1 | Global hot-plug interrupt enable |
| msg_sel | input | 1 | 1 = message interrupt, 0 = legacy interrupt |
| clr_w1c | input | 1 | Write-one strobe clearing `chg_sts` |
| latch_open | output | 1 | Debounced latch state |
| chg_sts | output | 1 | Sticky change flag |
| irq_msi | output | 1 | Interrupt request, message mode |
| irq_intx | output | 1 | Interrupt request, legacy mode |

## Verification
The debounce is swept with runs of 1 to 12 ticks of a differing level, alternating the direction of the transition. This shows the exact acceptance threshold and that extra ticks past acceptance do nothing. A glitch pattern (partial run, return, partial run) separates a restarting counter from one that accumulates. All sixteen combinations of the change flag, the two enables and the mode are applied to the interrupt outputs. The clear strobe is tried both alone and aligned with an accepted change, to confirm which of the two wins.

// File: rtl/latch_sense_pkg.sv
package latch_sense_pkg;
  // true when one more differing tick completes the stability window
  function automatic logic dbnc_done(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  // level interrupt request condition
  function automatic logic irq_req(input logic sts, input logic en, input logic ie);
    return sts & en & ie;
  endfunction
endpackage

// File: rtl/ls_sync.sv
module ls_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_in};
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/ls_debounce.sv
module ls_debounce
  import latch_sense_pkg::*;
#(
  parameter int STABLE_MS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic ms_tick,
  output logic stable_q,
  output logic chg_pulse
);
  localparam int CNT_W  = $clog2(STABLE_MS + 1);
  localparam int FILL_W = $clog2(SYNC_STAGES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;
  logic              primed_q;
  logic              differ;
  logic              accept;
  logic              fill_ready;

  assign differ     = primed_q && (smp != stable_q);
  assign accept     = differ && ms_tick && dbnc_done(int'(cnt_q), STABLE_MS);
  assign fill_ready = (fill_q == FILL_W'(SYNC_STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      primed_q  <= 1'b0;
      stable_q  <= 1'b1;
      cnt_q     <= '0;
      chg_pulse <= 1'b0;
    end else begin
      chg_pulse <= 1'b0;
      if (!primed_q) begin
        if (fill_ready) begin
          stable_q <= smp;
          primed_q <= 1'b1;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end else if (!differ) begin
        cnt_q <= '0;
      end else if (ms_tick) begin
        if (accept) begin
          stable_q  <= smp;
          cnt_q     <= '0;
          chg_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !ms_tick) |=> $stable(stable_q)); // R2
  AST_NO_EVT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> !chg_pulse); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(STABLE_MS)); // R2
endmodule

// File: rtl/ls_status.sv
module ls_status
  import latch_sense_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_pulse,
  input  logic clr_w1c,
  input  logic chg_en,
  input  logic hp_irq_en,
  input  logic msg_sel,
  output logic sts_q,
  output logic irq_msi,
  output logic irq_intx
);
  logic req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sts_q <= 1'b0;
    else if (chg_pulse) sts_q <= 1'b1;
    else if (clr_w1c)   sts_q <= 1'b0;
  end

  assign req      = irq_req(sts_q, chg_en, hp_irq_en);
  assign irq_msi  = req & msg_sel;
  assign irq_intx = req & ~msg_sel;

  AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse |=> sts_q); // R4
  AST_STS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(chg_pulse)); // R6
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && !chg_pulse) |=> !sts_q); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_msi && irq_intx)); // R10
endmodule

// File: rtl/latch_sensor_evt.sv
module latch_sensor_evt #(
  parameter int STABLE_MS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sensor_n,
  input  logic ms_tick,
  input  logic chg_en,
  input  logic hp_irq_en,
  input  logic msg_sel,
  input  logic clr_w1c,
  output logic latch_open,
  output logic chg_sts,
  output logic irq_msi,
  output logic irq_intx
);
  logic smp;
  logic chg_evt;

  ls_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sensor_n), .d_out(smp)
  );

  ls_debounce #(.STABLE_MS(STABLE_MS), .SYNC_STAGES(SYNC_STAGES)) u_dbnc (
    .clk(clk), .rst_n(rst_n), .smp(smp), .ms_tick(ms_tick),
    .stable_q(latch_open), .chg_pulse(chg_evt)
  );

  ls_status u_sts (
    .clk(clk), .rst_n(rst_n), .chg_pulse(chg_evt), .clr_w1c(clr_w1c),
    .chg_en(chg_en), .hp_irq_en(hp_irq_en), .msg_sel(msg_sel),
    .sts_q(chg_sts), .irq_msi(irq_msi), .irq_intx(irq_intx)
  );

  AST_STATE_MOVES_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> (latch_open != $past(latch_open))); // R4
endmodule

// File: tb/tb_latch_sensor_evt.sv
`timescale 1ns/1ps
module tb_latch_sensor_evt;
  localparam int STABLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sensor_n = 1'b0, ms_tick = 1'b0, chg_en = 1'b0, hp_irq_en = 1'b0;
  logic msg_sel = 1'b0, clr_w1c = 1'b0;
  logic latch_open, chg_sts, irq_msi, irq_intx;
  int checks = 0, errors = 0;
  logic cur;

  always #5 clk = ~clk;

  latch_sensor_evt #(.STABLE_MS(STABLE), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sensor_n(sensor_n), .ms_tick(ms_tick),
    .chg_en(chg_en), .hp_irq_en(hp_irq_en), .msg_sel(msg_sel), .clr_w1c(clr_w1c),
    .latch_open(latch_open), .chg_sts(chg_sts), .irq_msi(irq_msi), .irq_intx(irq_intx)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; @(negedge clk);
  endtask

  task automatic clear();
    clr_w1c = 1'b1; @(negedge clk); clr_w1c = 1'b0; @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 open", latch_open, 1'b1);
    chk("R11 sts", chg_sts, 1'b0);
    chk("R11 msi", irq_msi, 1'b0);
    chk("R11 intx", irq_intx, 1'b0);
    rst_n = 1'b1;
    cyc(4);
    chk("R5 direct load", latch_open, 1'b0);
    chk("R1 closed reads 0", latch_open, 1'b0);
    chk("R6 no sts on load", chg_sts, 1'b0);
    cur = 1'b0;

    // R2 / R4 sweep over run length, alternating direction
    for (int n = 1; n <= 12; n++) begin
      logic exp_chg;
      exp_chg = (n >= STABLE);
      sensor_n = ~cur;
      cyc(4);
      for (int t = 0; t < n; t++) tick();
      cyc(1);
      chk($sformatf("R2 n=%0d state", n), latch_open, exp_chg ? ~cur : cur);
      chk($sformatf("R4 n=%0d sts", n), chg_sts, exp_chg);
      if (exp_chg) begin
        cur = ~cur;
        chk("R1 level", latch_open, sensor_n);
      end
      sensor_n = cur;
      cyc(4);
      clear();
      chk("R7 clear", chg_sts, 1'b0);
    end

    // R3 glitch restarts count
    sensor_n = ~cur; cyc(4);
    for (int t = 0; t < STABLE-2; t++) tick();
    sensor_n = cur; cyc(4);
    sensor_n = ~cur; cyc(4);
    for (int t = 0; t < STABLE-1; t++) tick();
    chk("R3 restart", latch_open, cur);
    chk("R3 no sts", chg_sts, 1'b0);
    tick(); cyc(1);
    chk("R3 accepted", latch_open, ~cur);
    cur = ~cur;
    clear();

    // R8 clear collides with acceptance
    sensor_n = ~cur; cyc(4);
    for (int t = 0; t < STABLE-1; t++) tick();
    ms_tick = 1'b1; @(negedge clk);
    ms_tick = 1'b0; clr_w1c = 1'b1; @(negedge clk);
    clr_w1c = 1'b0; @(negedge clk);
    chk("R8 change wins", chg_sts, 1'b1);
    cur = ~cur;

    // R9 / R10 all combinations
    for (int c = 0; c < 16; c++) begin
      logic s, e, ie, m, req;
      {s, e, ie, m} = 4'(c);
      if (!s) clear();
      chg_en = e; hp_irq_en = ie; msg_sel = m;
      cyc(1);
      req = s & e & ie;
      chk($sformatf("R10 msi c=%0d", c), irq_msi, req & m);
      chk($sformatf("R10 intx c=%0d", c), irq_intx, req & ~m);
      cyc(5);
      chk($sformatf("R9 held c=%0d", c), irq_msi | irq_intx, req);
      if (!s && c < 8) begin
        // re-arm sts for the upper half
        sensor_n = ~cur; cyc(4);
        for (int t = 0; t < STABLE; t++) tick();
        cur = ~cur; cyc(1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule